// File: doc/BRIEF.md
# Sequential Multiply/Divide Engine for a 16-bit Accumulator Datapath

This engine performs unsigned and signed multiplication and division for a processor whose arithmetic results live in an accumulator pair: a low accumulator (AX) and a high extension register (DX). Byte forms work on the low half of AX with an 8-bit source and produce a 16-bit result. Word forms work on AX, or on DX:AX for division, with a 16-bit source. The operation is chosen by a 2-bit code and a size bit. The caller presents the current AX, DX and source value and raises `start` for one cycle. The engine then works one bit per clock. When `done` pulses, it returns the new AX and DX, the carry and overflow flags, and a divide-error indication.

Multiplication uses shift-and-add on operand magnitudes, and signed results are corrected afterwards. Division uses a restoring algorithm on magnitudes. It produces a quotient that truncates toward zero and a remainder that carries the sign of the dividend. A zero divisor, or a quotient too wide for its destination, is reported as a divide error, and in that case AX and DX come back exactly as they were presented.

Top module: `muldiv_unit`

## Requirements
- R1: Byte multiply (`wordSize`=0) multiplies AL (`axIn[7:0]`) by `srcIn[7:0]` and writes the 16-bit product to `axOut`. `dxOut` returns the `dxIn` value captured at start. `opSel`=2'b00 is unsigned and 2'b01 is signed.
- R2: Word multiply (`wordSize`=1) multiplies `axIn` by `srcIn`. It writes the high product word to `dxOut` and the low word to `axOut`.
- R3: For unsigned multiply, `cfOut` and `ofOut` are both 1 when the upper half of the product (bits 15:8 for byte, `dxOut` for word) is nonzero, and both 0 otherwise.
- R4: For signed multiply, `cfOut` and `ofOut` are both 0 only when the upper half equals the sign extension of the lower half's top bit; otherwise both are 1.
- R5: Byte divide (`opSel`=2'b10 unsigned, 2'b11 signed) divides `axIn` by `srcIn[7:0]`. It writes the quotient to `axOut[7:0]` and the remainder to `axOut[15:8]`, and `dxOut` returns the captured `dxIn`.
- R6: Word divide divides the 32-bit value {`dxIn`,`axIn`} by `srcIn`. It writes the quotient to `axOut` and the remainder to `dxOut`.
- R7: Signed divide truncates the quotient toward zero, and the remainder has the sign of the dividend (for example, -7/2 gives quotient -3 and remainder -1).
- R8: A zero divisor, or a quotient outside the destination range (unsigned 0..2^N-1; signed -2^(N-1)..2^(N-1)-1, with N=8 or 16), sets `divErr`=1. In that case `axOut` and `dxOut` equal the `axIn` and `dxIn` captured at start.
- R9: A divide leaves `cfOut` and `ofOut` at their previous values. A multiply clears `divErr`, and a divide without error also clears it.
- R10: `start` is taken only while `busy` is 0. `busy` then stays high for N+1 cycles (N=8 for byte, N=16 for word), and `done` pulses for exactly one cycle right after `busy` falls. A `start` raised while busy is ignored.
- R11: After reset, `axOut`, `dxOut`, `cfOut`, `ofOut`, `divErr`, `busy` and `done` are all 0.
- R12: All result outputs hold their values in every cycle in which `done` is not asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken when idle) |
| opSel | input | 2 | bit1: divide, bit0: signed |
| wordSize | input | 1 | 1 = word form, 0 = byte form |
| axIn | input | 16 | Current accumulator low register |
| dxIn | input | 16 | Current accumulator high register |
| srcIn | input | 16 | Source operand (low byte in byte form) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| axOut | output | 16 | Result accumulator low register |
| dxOut | output | 16 | Result accumulator high register |
| cfOut | output | 1 | Carry flag |
| ofOut | output | 1 | Overflow flag |
| divErr | output | 1 | Divide error: zero divisor or quotient overflow |

## Verification
Directed products pair small operands, whose upper half stays clear, with full-scale ones such as 0xFF·0xFF and -128·2. This tells the unsigned zero-upper-half flag rule apart from the signed sign-extension rule. Directed divisions mix the signs of dividend and divisor to separate truncation toward zero from floor rounding. They also sit exactly on the signed quotient limits: -256/2 fits, while -128/-1 and 0x1000/2 overflow. Zero divisors are included too. Several hundred random operations in all four modes and both sizes are compared on every clock against an integer model. One operation is hit by a second `start` while busy, which shows whether the engine ever accepts a request mid-operation.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [1:0] {
    OP_MULU = 2'b00,
    OP_MULS = 2'b01,
    OP_DIVU = 2'b10,
    OP_DIVS = 2'b11
  } mdOp_e;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } mdStrobe_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      wordSize,
  output mdStrobe_t strb,
  output logic      busy,
  output logic      done
);
  localparam int H  = W / 2;
  localparam int CW = $clog2(W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} ctrlState_e;

  ctrlState_e       state;
  logic [CW-1:0]    bitsLeft;

  always_comb begin
    strb.load   = (state == ST_IDLE) && start;
    strb.step   = (state == ST_RUN);
    strb.finish = (state == ST_FIN);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitsLeft <= '0;
      done     <= 1'b0;
    end else begin
      done <= (state == ST_FIN);
      case (state)
        ST_IDLE: if (start) begin
          bitsLeft <= wordSize ? CW'(W) : CW'(H);
          state    <= ST_RUN;
        end
        ST_RUN: begin
          bitsLeft <= bitsLeft - 1'b1;
          if (bitsLeft == CW'(1)) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdu_dpath.sv
module mdu_dpath
  import mdu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  mdStrobe_t    strb,
  input  logic [1:0]   opSel,
  input  logic         wordSize,
  input  logic [W-1:0] axIn,
  input  logic [W-1:0] dxIn,
  input  logic [W-1:0] srcIn,
  output logic [W-1:0] axOut,
  output logic [W-1:0] dxOut,
  output logic         cfOut,
  output logic         ofOut,
  output logic         divErr
);
  localparam int H  = W / 2;
  localparam int W2 = 2 * W;

  // captured operation state
  logic [1:0]    opR;
  logic          wordR;
  logic [W-1:0]  axHold, dxHold;
  logic [W-1:0]  magB;
  logic [W-1:0]  remR;
  logic [W-1:0]  lowR;
  logic [W2-1:0] prodR;
  logic          negQ, negR, tooBig;

  // operand preparation at load
  logic          signedOp, isDiv;
  logic [W-1:0]  aExt, bExt, aMag, bMag;
  logic          aNeg, bNeg, dNeg;
  logic [W2-1:0] dExt, dMag, dAlign;

  always_comb begin
    signedOp = opSel[0];
    isDiv    = opSel[1];
    aExt = wordSize ? axIn  : {{H{signedOp & axIn[H-1]}},  axIn[H-1:0]};
    bExt = wordSize ? srcIn : {{H{signedOp & srcIn[H-1]}}, srcIn[H-1:0]};
    aNeg = signedOp & aExt[W-1];
    bNeg = signedOp & bExt[W-1];
    aMag = aNeg ? -aExt : aExt;
    bMag = bNeg ? -bExt : bExt;
    dExt = wordSize ? {dxIn, axIn} : {{W{signedOp & axIn[W-1]}}, axIn};
    dNeg = signedOp & dExt[W2-1];
    dMag = dNeg ? -dExt : dExt;
    dAlign = wordSize ? dMag : (dMag << H);
  end

  // one iteration
  logic [W:0]    trial, diff;
  logic          fits;
  logic [W2-1:0] addend;

  always_comb begin
    trial  = {remR, lowR[W-1]};
    fits   = (trial >= {1'b0, magB});
    diff   = trial - {1'b0, magB};
    addend = lowR[W-1] ? {{W{1'b0}}, magB} : '0;
  end

  // result shaping at finish
  logic [W2-1:0] prodS;
  logic          mulWide;
  logic [W-1:0]  qMag, qS, rS, halfTop, qLim;
  logic          qOvf, divFail;

  always_comb begin
    prodS = negQ ? -prodR : prodR;
    if (wordR)
      mulWide = opR[0] ? (prodS[W2-1:W] != {W{prodS[W-1]}}) : (prodS[W2-1:W] != '0);
    else
      mulWide = opR[0] ? (prodS[W-1:H] != {H{prodS[H-1]}}) : (prodS[W-1:H] != '0);
    qMag    = wordR ? lowR : {{H{1'b0}}, lowR[H-1:0]};
    halfTop = wordR ? (W'(1) << (W - 1)) : (W'(1) << (H - 1));
    qLim    = opR[0] ? (negQ ? halfTop : halfTop - 1'b1) : '1;
    qOvf    = (qMag > qLim);
    divFail = tooBig | qOvf;
    qS      = negQ ? -qMag : qMag;
    rS      = negR ? -remR : remR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opR <= '0; wordR <= 1'b0; axHold <= '0; dxHold <= '0;
      magB <= '0; remR <= '0; lowR <= '0; prodR <= '0;
      negQ <= 1'b0; negR <= 1'b0; tooBig <= 1'b0;
      axOut <= '0; dxOut <= '0; cfOut <= 1'b0; ofOut <= 1'b0; divErr <= 1'b0;
    end else begin
      if (strb.load) begin
        opR    <= opSel;
        wordR  <= wordSize;
        axHold <= axIn;
        dxHold <= dxIn;
        magB   <= bMag;
        prodR  <= '0;
        if (isDiv) begin
          remR   <= dAlign[W2-1:W];
          lowR   <= dAlign[W-1:0];
          negQ   <= dNeg ^ bNeg;
          negR   <= dNeg;
          tooBig <= (dAlign[W2-1:W] >= bMag);
        end else begin
          remR   <= '0;
          lowR   <= wordSize ? aMag : (aMag << H);
          negQ   <= aNeg ^ bNeg;
          negR   <= 1'b0;
          tooBig <= 1'b0;
        end
      end

      if (strb.step) begin
        if (opR[1]) begin
          remR <= fits ? diff[W-1:0] : trial[W-1:0];
          lowR <= {lowR[W-2:0], fits};
        end else begin
          prodR <= (prodR << 1) + addend;
          lowR  <= lowR << 1;
        end
      end

      if (strb.finish) begin
        if (!opR[1]) begin
          divErr <= 1'b0;
          cfOut  <= mulWide;
          ofOut  <= mulWide;
          axOut  <= prodS[W-1:0];
          dxOut  <= wordR ? prodS[W2-1:W] : dxHold;
        end else if (divFail) begin
          divErr <= 1'b1;
          axOut  <= axHold;
          dxOut  <= dxHold;
        end else begin
          divErr <= 1'b0;
          axOut  <= wordR ? qS : {rS[H-1:0], qS[H-1:0]};
          dxOut  <= wordR ? rS : dxHold;
        end
      end
    end
  end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import mdu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   opSel,
  input  logic         wordSize,
  input  logic [W-1:0] axIn,
  input  logic [W-1:0] dxIn,
  input  logic [W-1:0] srcIn,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] axOut,
  output logic [W-1:0] dxOut,
  output logic         cfOut,
  output logic         ofOut,
  output logic         divErr
);
  mdStrobe_t strb;

  mdu_ctrl #(.W(W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .wordSize(wordSize),
    .strb(strb), .busy(busy), .done(done)
  );

  mdu_dpath #(.W(W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .opSel(opSel), .wordSize(wordSize),
    .axIn(axIn), .dxIn(dxIn), .srcIn(srcIn),
    .axOut(axOut), .dxOut(dxOut), .cfOut(cfOut), .ofOut(ofOut), .divErr(divErr)
  );

endmodule

// File: rtl/mdu_chk.sv
module mdu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] axOut,
  input logic [W-1:0] dxOut,
  input logic         cfOut,
  input logic         ofOut,
  input logic         divErr
);
  localparam int CW = $clog2(W + 3);
  logic [CW-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else busyRun <= '0;
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));

  // R10
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun <= CW'(W)));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(axOut) && $stable(dxOut) && $stable(cfOut)
               && $stable(ofOut) && $stable(divErr)));

endmodule

bind muldiv_unit mdu_chk #(.W(W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .axOut(axOut), .dxOut(dxOut), .cfOut(cfOut), .ofOut(ofOut), .divErr(divErr)
);

// File: tb/muldiv_unit_tb_top.sv
`timescale 1ns/1ps
module muldiv_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic        wordSize = 1'b0;
  logic [15:0] axIn = '0, dxIn = '0, srcIn = '0;
  logic        busy, done, cfOut, ofOut, divErr;
  logic [15:0] axOut, dxOut;

  always #2.5 clk = ~clk;

  muldiv_unit dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .wordSize(wordSize),
    .axIn(axIn), .dxIn(dxIn), .srcIn(srcIn),
    .busy(busy), .done(done), .axOut(axOut), .dxOut(dxOut),
    .cfOut(cfOut), .ofOut(ofOut), .divErr(divErr)
  );

  int vectors = 0;
  int misses = 0;
  int cycles = 0;
  bit finished = 0;
  bit anyOp = 0;

  // reference model state
  int          mCnt = 0;
  bit          mDone = 0;
  logic [15:0] mAx = '0, mDx = '0;
  bit          mCf = 0, mOf = 0, mErr = 0;
  logic [15:0] pAx, pDx;
  bit          pCf, pOf, pErr;
  string       pTag = "R11";

  task automatic computeRef(input logic [1:0] op, input logic w,
                            input logic [15:0] a, d, s);
    longint x, y, p, q, r, lo, hi;
    int n;
    bit sg;
    n  = w ? 16 : 8;
    sg = op[0];
    pErr = 0; pCf = mCf; pOf = mOf; pAx = a; pDx = d;
    if (!op[1]) begin
      if (w) begin
        x = sg ? longint'($signed(a)) : longint'(a);
        y = sg ? longint'($signed(s)) : longint'(s);
      end else begin
        x = sg ? longint'($signed(a[7:0])) : longint'(a[7:0]);
        y = sg ? longint'($signed(s[7:0])) : longint'(s[7:0]);
      end
      p = x * y;
      if (sg) begin
        lo = -(longint'(1) << (n - 1));
        hi = (longint'(1) << (n - 1)) - 1;
        pCf = (p < lo) || (p > hi);
      end else begin
        pCf = (p >> n) != 0;
      end
      pOf = pCf;
      pAx = p[15:0];
      pDx = w ? p[31:16] : d;
      pTag = w ? (sg ? "R2,R4" : "R2,R3") : (sg ? "R1,R4" : "R1,R3");
    end else begin
      if (w) begin
        x = sg ? longint'($signed({d, a})) : longint'({d, a});
        y = sg ? longint'($signed(s)) : longint'(s);
      end else begin
        x = sg ? longint'($signed(a)) : longint'(a);
        y = sg ? longint'($signed(s[7:0])) : longint'(s[7:0]);
      end
      if (y == 0) begin
        pErr = 1;
      end else begin
        q = x / y;
        r = x % y;
        if (sg) begin
          lo = -(longint'(1) << (n - 1));
          hi = (longint'(1) << (n - 1)) - 1;
        end else begin
          lo = 0;
          hi = (longint'(1) << n) - 1;
        end
        if (q < lo || q > hi) pErr = 1;
        else begin
          pAx = w ? q[15:0] : {r[7:0], q[7:0]};
          pDx = w ? r[15:0] : d;
        end
      end
      if (pErr) pTag = "R8";
      else if (sg) pTag = w ? "R6,R7,R9" : "R5,R7,R9";
      else pTag = w ? "R6,R9" : "R5,R9";
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mDone = 0; mAx = '0; mDx = '0; mCf = 0; mOf = 0; mErr = 0;
    end else begin
      mDone = 0;
      if (mCnt > 0) begin
        mCnt = mCnt - 1;
        if (mCnt == 0) begin
          mDone = 1; mAx = pAx; mDx = pDx; mCf = pCf; mOf = pOf; mErr = pErr;
        end
      end else if (start) begin
        computeRef(opSel, wordSize, axIn, dxIn, srcIn);
        mCnt = (wordSize ? 16 : 8) + 1;
        anyOp = 1;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    string tag;
    bit bad;
    if (rstN && !finished) begin
      tag = mDone ? pTag : (anyOp ? "R10,R12" : "R11");
      bad = 0;
      vectors++;
      if (busy !== (mCnt > 0)) begin
        $display("FAIL %s busy: got %0b expected %0b", "R10", busy, mCnt > 0); bad = 1;
      end
      if (done !== mDone) begin
        $display("FAIL %s done: got %0b expected %0b", "R10", done, mDone); bad = 1;
      end
      if (axOut !== mAx) begin
        $display("FAIL %s axOut: got %h expected %h", tag, axOut, mAx); bad = 1;
      end
      if (dxOut !== mDx) begin
        $display("FAIL %s dxOut: got %h expected %h", tag, dxOut, mDx); bad = 1;
      end
      if (cfOut !== mCf || ofOut !== mOf) begin
        $display("FAIL %s cf/of: got %0b/%0b expected %0b/%0b", tag, cfOut, ofOut, mCf, mOf); bad = 1;
      end
      if (divErr !== mErr) begin
        $display("FAIL %s divErr: got %0b expected %0b", tag, divErr, mErr); bad = 1;
      end
      if (bad) misses++;
    end
  end

  task automatic doOp(input logic [1:0] op, input logic w,
                      input logic [15:0] a, d, s, input bit poke);
    @(negedge clk);
    opSel = op; wordSize = w; axIn = a; dxIn = d; srcIn = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10: a second request while busy must be ignored
      repeat (2) @(negedge clk);
      opSel = ~op; axIn = ~a; srcIn = s + 16'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    repeat (w ? 19 : 11) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);   // R11 reset state compared here

    // R1 R3: unsigned byte
    doOp(2'b00, 0, 16'h0003, 16'h5A5A, 16'h0004, 0);
    doOp(2'b00, 0, 16'h12FF, 16'h1111, 16'h00FF, 0);
    // R1 R4: signed byte
    doOp(2'b01, 0, 16'h00FF, 16'h2222, 16'h00FF, 0);
    doOp(2'b01, 0, 16'h0080, 16'h3333, 16'h0002, 0);
    doOp(2'b01, 0, 16'h00C0, 16'h0000, 16'h0002, 0);
    // R2 R3 R4: word
    doOp(2'b00, 1, 16'hFFFF, 16'h0000, 16'hFFFF, 0);
    doOp(2'b00, 1, 16'h0100, 16'h7777, 16'h00FF, 0);
    doOp(2'b01, 1, 16'hFFFF, 16'h0000, 16'h0005, 0);
    doOp(2'b01, 1, 16'h8000, 16'h0000, 16'h0002, 0);
    // R5 R9: byte divide, flags stay from last multiply
    doOp(2'b10, 0, 16'd100, 16'h4444, 16'd7, 0);
    // R6: word divide
    doOp(2'b10, 1, 16'h2345, 16'h0001, 16'h0100, 0);
    // R7: signed truncation toward zero
    doOp(2'b11, 0, 16'hFFF9, 16'h0000, 16'h0002, 0);
    doOp(2'b11, 0, 16'h0007, 16'h0000, 16'h00FE, 0);
    doOp(2'b11, 1, 16'hFFF9, 16'hFFFF, 16'h0002, 0);
    doOp(2'b11, 0, 16'hFF00, 16'h0000, 16'h0002, 0);
    // R8: errors
    doOp(2'b10, 0, 16'h1234, 16'h9999, 16'h0000, 0);
    doOp(2'b10, 0, 16'h1000, 16'h8888, 16'h0002, 0);
    doOp(2'b11, 0, 16'hFF80, 16'h6666, 16'h00FF, 0);
    doOp(2'b11, 1, 16'h0000, 16'h8000, 16'hFFFF, 0);
    doOp(2'b10, 1, 16'h0000, 16'h0005, 16'h0005, 0);
    // R9: multiply clears divErr
    doOp(2'b00, 0, 16'h0002, 16'h0000, 16'h0003, 0);
    // R10: start while busy
    doOp(2'b00, 1, 16'h1234, 16'h0000, 16'h5678, 1);
    doOp(2'b11, 0, 16'hFF9C, 16'h0000, 16'h0007, 1);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] s;
      logic [15:0] d;
      s = 16'($urandom);
      if (($urandom % 8) == 0) s = '0;
      d = 16'($urandom);
      if (($urandom % 3) == 0) d = 16'($urandom % 4);
      doOp(2'($urandom), 1'($urandom), 16'($urandom), d, s, ($urandom % 10) == 0);
    end

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      misses++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule